// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block is the single data window through which a host CPU reads and writes a network controller's packet memory. The host first loads a remote byte address and a remaining byte count, then issues a stream of accesses on one data port. Each access moves either one byte or one little-endian 16-bit word at the current remote address. After the access the address steps forward, the count steps down, and the address folds back to the start of the receive ring when it lands on the ring's stop address. When the count runs out, a one-cycle completion pulse tells the interrupt logic to raise its remote-DMA-done status.

Packet memory sits outside the block on a 16-bit word port with byte enables. Only two windows of the byte address space are backed by memory: a 32-byte station-address PROM image at the bottom and a packet buffer from 16 KB up to 48 KB. The block also rebuilds the PROM image. It does this after hardware reset and again whenever the host reads the soft-reset port, and it reports the end of the rebuild with a pulse that sets the reset-done status.

The control is a three-state machine. ST_FILL writes the PROM image one word per cycle. ST_NOTIFY asserts the rebuild-done pulse for one cycle. ST_IDLE serves host accesses. The transitions are: reset enters ST_FILL; ST_FILL goes to ST_NOTIFY after the last PROM word; ST_NOTIFY goes to ST_IDLE unconditionally; ST_IDLE goes to ST_FILL on a soft-reset read.

Top module: `rdma_port`

## Requirements
- R1: While rst_n is low, cur_addr, cur_cnt and host_rdata are 0 and rdc_pulse is 0. The first cycle after release starts the PROM rebuild.
- R2: A rebuild lasts 16 cycles. In cycle i it writes memory word i (byte addresses 2i and 2i+1) with mem_be=2'b11 and the same value in both bytes. That value is byte i of station_addr (bits 8i+7:8i) for i below 6, 0x57 for i of 14 or 15, and 0x00 otherwise. prom_done is then high for exactly one cycle, and the block returns to idle. Host accesses during the rebuild and during the prom_done cycle are ignored.
- R3: rst_port_rd while idle starts a new rebuild. A host access in the same cycle is ignored.
- R4: With word_mode=0, each access adds 1 to the address and subtracts 1 from the count. The count saturates at 0.
- R5: With word_mode=1, each access adds 2 to the address (taken as issued, even if odd) and subtracts 2 from the count. The count saturates at 0, so an odd count cannot wrap.
- R6: If the stepped address equals ring_stop, cur_addr becomes ring_start instead.
- R7: rdc_pulse is high for one cycle, in the cycle after any access whose resulting count is 0. This includes reads issued at count 0.
- R8: A host write issued while cur_cnt is 0 does nothing: no memory write, no address or count change, no rdc_pulse. A read at count 0 still proceeds.
- R9: Only byte addresses below 32, and those from 16384 up to but not including 49152, are backed by memory. Writes elsewhere produce no mem_we. Reads elsewhere return 0x00FF in byte mode and 0xFFFF in word mode.
- R10: A word access uses the address with bit 0 cleared. The even byte is bits 7:0 (mem_be[0] lane). A byte access uses lane addr[0], puts the write byte on both lanes, and returns {8'h00, byte}. host_rdata is updated in the cycle after a read and is held otherwise.
- R11: ld_addr and ld_cnt load addr_in and cnt_in, visible one cycle later. A load takes precedence over an access update of the same field.
- R12: If host_rd and host_wr are both high, the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe on the data port, one access per cycle |
| host_wr | input | 1 | Host write strobe on the data port |
| host_wdata | input | 16 | Host write data (bits 7:0 only in byte mode) |
| host_rdata | output | 16 | Registered read data of the last read |
| word_mode | input | 1 | 1 selects 16-bit transfers |
| ld_addr | input | 1 | Load strobe for the remote address |
| addr_in | input | 16 | Remote address to load |
| ld_cnt | input | 1 | Load strobe for the remaining count |
| cnt_in | input | 16 | Remaining byte count to load |
| ring_start | input | 16 | Ring start byte address |
| ring_stop | input | 16 | Ring stop byte address |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| rst_port_rd | input | 1 | Host read of the soft-reset port |
| cur_addr | output | 16 | Current remote address |
| cur_cnt | output | 16 | Remaining byte count |
| mem_addr | output | 15 | Packet memory word address |
| mem_we | output | 1 | Packet memory write enable |
| mem_be | output | 2 | Byte enables, bit 0 is the even byte |
| mem_wdata | output | 16 | Packet memory write data |
| mem_rdata | input | 16 | Packet memory read data, combinational to mem_addr |
| rdc_pulse | output | 1 | Remote transfer complete pulse |
| prom_done | output | 1 | PROM rebuild complete pulse |

## Verification
The address fold and the completion pulse can come from the same access. This happens when the last counted byte or word sits just below ring_stop. The bench provokes it by loading a ring of four bytes and a count of four, and by word transfers that end exactly at the stop address. In that cycle it expects cur_addr to equal ring_start, cur_cnt to be 0 and rdc_pulse high. A behavioural reference model, stepped every clock, judges every output, so a fold or a pulse missing from such a cycle shows up as a mismatch on that very cycle.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_NOTIFY = 2'd1,
        ST_IDLE   = 2'd2
    } rdp_state_e;
endpackage

// File: rtl/rdp_step.sv
// Computes the post-access remote address and remaining count.
module rdp_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cnt,
    input  logic          word,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_stop,
    output logic [AW-1:0] nxt_addr,
    output logic [AW-1:0] nxt_cnt,
    output logic          cnt_zero
);
    logic [AW-1:0] stride;
    logic [AW-1:0] sum;

    always_comb begin
        stride   = word ? AW'(2) : AW'(1);
        sum      = addr + stride;
        nxt_addr = (sum == ring_stop) ? ring_start : sum;
        nxt_cnt  = (cnt < stride) ? '0 : cnt - stride;
        cnt_zero = (nxt_cnt == '0);
    end
endmodule

// File: rtl/rdp_lane.sv
// Address decode, byte-lane steering and read-data formatting.
module rdp_lane #(
    parameter int AW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int BUF_LO     = 16384,
    parameter int BUF_HI     = 49152
) (
    input  logic [AW-1:0] addr,
    input  logic          word,
    input  logic [15:0]   wdata_in,
    input  logic [15:0]   mem_rdata,
    output logic          hit,
    output logic [AW-2:0] word_addr,
    output logic [1:0]    be,
    output logic [15:0]   wdata,
    output logic [15:0]   rdata
);
    localparam logic [AW:0] PROM_L = (AW+1)'(PROM_BYTES);
    localparam logic [AW:0] LO_L   = (AW+1)'(BUF_LO);
    localparam logic [AW:0] HI_L   = (AW+1)'(BUF_HI);

    logic [AW-1:0] eff;
    logic [7:0]    pick;

    always_comb begin
        eff       = word ? {addr[AW-1:1], 1'b0} : addr;
        hit       = ({1'b0, eff} < PROM_L) ||
                    (({1'b0, eff} >= LO_L) && ({1'b0, eff} < HI_L));
        word_addr = eff[AW-1:1];
        be        = word ? 2'b11 : (eff[0] ? 2'b10 : 2'b01);
        wdata     = word ? wdata_in : {2{wdata_in[7:0]}};
        pick      = eff[0] ? mem_rdata[15:8] : mem_rdata[7:0];
        if (!hit)
            rdata = word ? 16'hFFFF : 16'h00FF;
        else
            rdata = word ? mem_rdata : {8'h00, pick};
    end
endmodule

// File: rtl/rdp_prom_gen.sv
// PROM image byte for a given word index.
module rdp_prom_gen #(
    parameter int         ENTRIES  = 16,
    parameter int         ID_BYTES = 6,
    parameter logic [7:0] SIG      = 8'h57,
    localparam int        IW       = $clog2(ENTRIES)
) (
    input  logic [IW-1:0]           idx,
    input  logic [8*ID_BYTES-1:0]   station_addr,
    output logic [7:0]              val
);
    logic [7:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
        if (g < ID_BYTES) begin : g_id
            assign tbl[g] = station_addr[g*8 +: 8];
        end else if (g >= ENTRIES - 2) begin : g_sig
            assign tbl[g] = SIG;
        end else begin : g_zero
            assign tbl[g] = 8'h00;
        end
    end

    assign val = tbl[idx];
endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdp_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int BUF_LO     = 16384,
    parameter int BUF_HI     = 49152,
    parameter int MAC_BYTES  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    input  logic                   word_mode,
    input  logic                   ld_addr,
    input  logic [AW-1:0]          addr_in,
    input  logic                   ld_cnt,
    input  logic [AW-1:0]          cnt_in,
    input  logic [AW-1:0]          ring_start,
    input  logic [AW-1:0]          ring_stop,
    input  logic [8*MAC_BYTES-1:0] station_addr,
    input  logic                   rst_port_rd,
    output logic [AW-1:0]          cur_addr,
    output logic [AW-1:0]          cur_cnt,
    output logic [AW-2:0]          mem_addr,
    output logic                   mem_we,
    output logic [1:0]             mem_be,
    output logic [15:0]            mem_wdata,
    input  logic [15:0]            mem_rdata,
    output logic                   rdc_pulse,
    output logic                   prom_done
);
    localparam int                PROM_WORDS = PROM_BYTES / 2;
    localparam int                FILL_W     = $clog2(PROM_WORDS);
    localparam logic [FILL_W-1:0] FILL_LAST  = FILL_W'(PROM_WORDS - 1);

    rdp_state_e        state, state_nxt;
    logic [FILL_W-1:0] fill_idx;
    logic              acc_rd, acc_wr, acc_any;
    logic [AW-1:0]     step_addr, step_cnt;
    logic              step_zero;
    logic              lane_hit;
    logic [AW-2:0]     lane_waddr;
    logic [1:0]        lane_be;
    logic [15:0]       lane_wdata, lane_rdata;
    logic [7:0]        fill_byte;

    rdp_step #(.AW(AW)) u_step (
        .addr(cur_addr), .cnt(cur_cnt), .word(word_mode),
        .ring_start(ring_start), .ring_stop(ring_stop),
        .nxt_addr(step_addr), .nxt_cnt(step_cnt), .cnt_zero(step_zero)
    );

    rdp_lane #(.AW(AW), .PROM_BYTES(PROM_BYTES), .BUF_LO(BUF_LO), .BUF_HI(BUF_HI)) u_lane (
        .addr(cur_addr), .word(word_mode), .wdata_in(host_wdata),
        .mem_rdata(mem_rdata), .hit(lane_hit), .word_addr(lane_waddr),
        .be(lane_be), .wdata(lane_wdata), .rdata(lane_rdata)
    );

    rdp_prom_gen #(.ENTRIES(PROM_WORDS), .ID_BYTES(MAC_BYTES)) u_prom (
        .idx(fill_idx), .station_addr(station_addr), .val(fill_byte)
    );

    // Host access qualification: only idle, reset-port read wins, read wins over write.
    always_comb begin
        acc_rd  = (state == ST_IDLE) && !rst_port_rd && host_rd;
        acc_wr  = (state == ST_IDLE) && !rst_port_rd && !host_rd && host_wr &&
                  (cur_cnt != '0);
        acc_any = acc_rd || acc_wr;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL:   if (fill_idx == FILL_LAST) state_nxt = ST_NOTIFY;
            ST_NOTIFY: state_nxt = ST_IDLE;
            ST_IDLE:   if (rst_port_rd) state_nxt = ST_FILL;
            default:   state_nxt = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        prom_done = (state == ST_NOTIFY);
        if (state == ST_FILL) begin
            mem_addr  = (AW-1)'(fill_idx);
            mem_we    = 1'b1;
            mem_be    = 2'b11;
            mem_wdata = {fill_byte, fill_byte};
        end else begin
            mem_addr  = lane_waddr;
            mem_we    = acc_wr && lane_hit;
            mem_be    = lane_be;
            mem_wdata = lane_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_FILL) fill_idx <= '0;
        else                            fill_idx <= fill_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            cur_cnt    <= '0;
            host_rdata <= '0;
            rdc_pulse  <= 1'b0;
        end else begin
            if (ld_addr)      cur_addr <= addr_in;
            else if (acc_any) cur_addr <= step_addr;
            if (ld_cnt)       cur_cnt  <= cnt_in;
            else if (acc_any) cur_cnt  <= step_cnt;
            if (acc_rd)       host_rdata <= lane_rdata;
            rdc_pulse <= acc_any && step_zero;
        end
    end

    // R8
    zero_cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !rst_port_rd && !host_rd && host_wr &&
         cur_cnt == '0 && !ld_addr && !ld_cnt)
        |=> ($stable(cur_addr) && cur_cnt == '0 && !rdc_pulse));

    // R7
    rdc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdc_pulse |-> (cur_cnt == '0 || $past(ld_cnt)));

    // R2
    fill_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> (mem_we && mem_be == 2'b11 &&
                                {1'b0, mem_addr} < AW'(PROM_WORDS)));

    // R2
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prom_done |=> !prom_done);

    // R11
    ld_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr |=> (cur_addr == $past(addr_in)));
endmodule

// File: tb/rdma_port_tb_top.sv
`timescale 1ns/1ps
module rdma_port_tb_top;
    localparam logic [47:0] MAC = 48'hA1B2_C3D4_E5F6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 0, host_wr = 0, word_mode = 0;
    logic [15:0] host_wdata = 0;
    logic        ld_addr = 0, ld_cnt = 0, rst_port_rd = 0;
    logic [15:0] addr_in = 0, cnt_in = 0, ring_start = 16'h4000, ring_stop = 16'h6000;
    logic [15:0] mem_rdata = 0;
    logic [15:0] host_rdata, cur_addr, cur_cnt, mem_wdata;
    logic [14:0] mem_addr;
    logic        mem_we, rdc_pulse, prom_done;
    logic [1:0]  mem_be;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // model state
    int m_addr, m_cnt, m_rdata, m_idx;
    bit m_rdc, m_fill, m_notify;
    bit [7:0] em [int];
    bit [7:0] bm [int];

    always #2 clk = ~clk;

    rdma_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .word_mode(word_mode),
        .ld_addr(ld_addr), .addr_in(addr_in), .ld_cnt(ld_cnt), .cnt_in(cnt_in),
        .ring_start(ring_start), .ring_stop(ring_stop), .station_addr(MAC),
        .rst_port_rd(rst_port_rd), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rdc_pulse(rdc_pulse), .prom_done(prom_done)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mapped_f(int a);
        return (a < 32) || (a >= 16384 && a < 49152);
    endfunction

    function automatic bit [7:0] pv(int i);
        if (i < 6)   return MAC[8*i +: 8];
        if (i >= 14) return 8'h57;
        return 8'h00;
    endfunction

    function automatic bit [7:0] erd(int a);
        return em.exists(a) ? em[a] : 8'h00;
    endfunction

    function automatic bit [7:0] brd(int a);
        return bm.exists(a) ? bm[a] : 8'h00;
    endfunction

    // One clock: predict, drive memory, compare.
    task automatic cyc();
        bit ew, idle, ard, awr, cw;
        int ea, eff, rv, na, nc, ca, st;
        logic [1:0] ebe, cbe;
        logic [15:0] ed, cd;
        #1;
        idle = !m_fill && !m_notify;
        ard  = idle && !rst_port_rd && host_rd;
        awr  = idle && !rst_port_rd && !host_rd && host_wr && (m_cnt != 0);
        eff  = word_mode ? (m_addr & 'hFFFE) : m_addr;
        ew = 0; ea = 0; ebe = 0; ed = 0;
        if (m_fill) begin
            ew = 1; ea = m_idx; ebe = 2'b11; ed = {pv(m_idx), pv(m_idx)};
        end else if (awr && mapped_f(eff)) begin
            ew = 1; ea = eff >> 1;
            ebe = word_mode ? 2'b11 : ((eff & 1) ? 2'b10 : 2'b01);
            ed  = word_mode ? host_wdata : {2{host_wdata[7:0]}};
        end
        // R8 R9 write suppression and decode
        chk(mem_we === ew, "R8 R9 mem_we", mem_we, ew);
        if (ew && mem_we === 1'b1) begin
            chk(int'(mem_addr) == ea, "R2 R10 mem_addr", mem_addr, ea);
            chk(mem_be == ebe, "R10 mem_be", mem_be, ebe);
            chk(mem_wdata == ed, "R2 R10 mem_wdata", mem_wdata, ed);
        end
        mem_rdata = {brd(2*int'(mem_addr)+1), brd(2*int'(mem_addr))};
        cw = (mem_we === 1'b1); ca = mem_addr; cbe = mem_be; cd = mem_wdata;
        if (word_mode) rv = mapped_f(eff) ? {erd(eff+1), erd(eff)} : 'hFFFF;
        else           rv = mapped_f(eff) ? {8'h00, erd(eff)} : 'h00FF;
        st = word_mode ? 2 : 1;
        na = (m_addr + st) & 'hFFFF;
        if (na == ring_stop) na = ring_start;
        nc = (m_cnt < st) ? 0 : m_cnt - st;
        @(posedge clk);
        if (cw) begin
            if (cbe[0]) bm[2*ca]   = cd[7:0];
            if (cbe[1]) bm[2*ca+1] = cd[15:8];
        end
        if (ew) begin
            if (ebe[0]) em[2*ea]   = ed[7:0];
            if (ebe[1]) em[2*ea+1] = ed[15:8];
        end
        m_rdc = (ard || awr) && (nc == 0);
        if (ard) m_rdata = rv;
        if (ld_addr) m_addr = addr_in; else if (ard || awr) m_addr = na;
        if (ld_cnt)  m_cnt  = cnt_in;  else if (ard || awr) m_cnt  = nc;
        if (m_fill) begin
            if (m_idx == 15) begin m_fill = 0; m_notify = 1; end
            else m_idx++;
        end else if (m_notify) m_notify = 0;
        else if (rst_port_rd) begin m_fill = 1; m_idx = 0; end
        @(negedge clk);
        chk(int'(cur_addr) == m_addr, "R4 R5 R6 R11 cur_addr", cur_addr, m_addr);
        chk(int'(cur_cnt) == m_cnt, "R4 R5 R11 cur_cnt", cur_cnt, m_cnt);
        chk(int'(host_rdata) == m_rdata, "R9 R10 host_rdata", host_rdata, m_rdata);
        chk(rdc_pulse == m_rdc, "R7 rdc_pulse", rdc_pulse, m_rdc);
        chk(prom_done == m_notify, "R2 prom_done", prom_done, m_notify);
    endtask

    task automatic clr();
        host_rd = 0; host_wr = 0; ld_addr = 0; ld_cnt = 0; rst_port_rd = 0;
    endtask

    task automatic load(int a, int c);
        ld_addr = 1; ld_cnt = 1; addr_in = 16'(a); cnt_in = 16'(c);
        cyc(); clr();
    endtask

    task automatic wr(int d);
        host_wr = 1; host_wdata = 16'(d); cyc(); clr();
    endtask

    task automatic rd();
        host_rd = 1; cyc(); clr();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cur_addr == 0, "R1 cur_addr", cur_addr, 0);
        chk(cur_cnt == 0, "R1 cur_cnt", cur_cnt, 0);
        chk(host_rdata == 0, "R1 host_rdata", host_rdata, 0);
        chk(rdc_pulse == 0, "R1 rdc_pulse", rdc_pulse, 0);
        rst_n = 1;
        m_addr = 0; m_cnt = 0; m_rdata = 0; m_rdc = 0; m_fill = 1; m_notify = 0; m_idx = 0;
        // R2 rebuild; host access during it is ignored
        host_rd = 1; repeat (5) cyc(); clr();
        repeat (13) cyc();
        // read back PROM bytewise
        load(0, 32);
        repeat (32) rd();
        // R6 with R7: fold and completion on the same access
        ring_start = 16'h4000; ring_stop = 16'h4004;
        load('h4000, 4);
        wr('hAA); wr('hBB); wr('hCC); wr('hDD);
        // R8 writes at zero count dropped, read at zero proceeds
        wr('h11); wr('h22);
        load('h4000, 0);
        rd();
        load('h4000, 4);
        repeat (4) rd();
        // R5 word mode, odd address, odd count saturates
        ring_stop = 16'h6000;
        word_mode = 1;
        load('h4101, 5);
        wr('h1234); wr('h5678); wr('h9ABC); wr('hDEF0);
        load('h4100, 6);
        repeat (3) rd();
        // word fold on stop
        ring_start = 16'h4200; ring_stop = 16'h4204;
        load('h4200, 4);
        wr('hCAFE); wr('hBEEF);
        load('h4200, 4);
        rd(); rd();
        // R9 unmapped accesses
        ring_stop = 16'h0000;
        load('h0100, 4); wr('h7777); rd();
        load('hBFFE, 6); rd(); wr('h4321); rd();
        load('hBFFE, 2); rd();
        word_mode = 0;
        load('h00FF, 3); rd(); wr('h55); rd();
        load('h001F, 2); wr('h66); load('h001F, 1); rd();
        // R12 read wins over write
        load('h4000, 2);
        host_rd = 1; host_wr = 1; host_wdata = 16'h99; cyc(); clr();
        // R3 reset-port read with concurrent access
        rst_port_rd = 1; host_wr = 1; host_wdata = 16'h42; cyc(); clr();
        repeat (18) cyc();
        load(0, 32);
        repeat (8) rd();
        // R11 load coincident with access
        load('h4000, 8);
        host_rd = 1; ld_addr = 1; addr_in = 16'h4010; cyc(); clr();
        // mixed traffic
        ring_start = 16'h5000; ring_stop = 16'h5010;
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 9);
            word_mode = $urandom_range(0, 1);
            if (r == 0) begin
                ld_addr = 1; addr_in = 16'($urandom_range('h4FF8, 'h500F));
                ld_cnt = 1; cnt_in = 16'($urandom_range(0, 12));
            end else if (r < 5) begin
                host_wr = 1; host_wdata = 16'($urandom);
            end else if (r < 9) begin
                host_rd = 1;
            end
            cyc(); clr();
        end
        finished = 1;
        summary();
        $finish;
    end
endmodule